// File: doc/BRIEF.md
# Shared-Prescaler Multi-Channel PWM Controller

This block drives a parameterised number of pulse-width outputs from a single shared timebase. An 8-bit prescaler divides the input clock into local ticks, and an 8-bit tick counter runs through 256 ticks per period. Every channel therefore has the same period, (prescaler+1)*256 input clocks. Each channel has its own 8-bit duty value. Its output is high from the start of a period for duty+1 ticks, so the largest duty value holds the output high through the whole period.

Software programs the block over a plain 32-bit register bus with a one-cycle registered read. A single global run bit starts and stops all channels together. New duty and prescaler values are held in shadow registers and are applied only when the tick counter wraps, so an output never shows a truncated or stretched pulse in the middle of a period. The register file also keeps an interrupt-enable flag that software can read back; it is connected to nothing.

Top module: `pwm_bank`

## Requirements
- R1: Channel n's duty value is held in the low 8 bits of the word at byte offset 4*n. Bits 31:8 read as 0. Read data appears on `rdata` after the rising edge that samples `rd_en`.
- R2: The control word is at byte offset 0x50. Prescaler bits [3:0] are control bits [3:0], prescaler bits [7:4] are control bits [14:11], and bit 9 is the global run flag. All other bits read 0, so writing all ones reads back 0x00007A0F.
- R3: The word at offset 0x54 stores a flag in bit 0 that reads back, with all other bits reading 0. This flag has no effect on any output.
- R4: A write to an unmapped or misaligned byte address (address bits [1:0] not 00) changes no register. A read from such an address returns 0.
- R5: While running, the period is 256*(P+1) input clocks for prescaler value P, for every P from 0 to 255, and all channels share that period.
- R6: With duty value D, an output is high for the first (D+1)*(P+1) clocks of each period and low for the rest. D=255 keeps the output high continuously and D=0 gives a one-tick pulse.
- R7: When a control write sets the run flag at rising edge E, the output after edge E+2 shows tick 0 of the first period, and periods then follow back to back.
- R8: A duty or prescaler value written during a period has no effect until the tick counter wraps. The new value then governs the whole of the next period.
- R9: Clearing the run flag at edge E drives every output low after edge E+2 and stops the counters. Setting the run flag again restarts at tick 0.
- R10: After synchronous reset every register reads 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_out | output | NCH | Registered pulse outputs, one per channel |

## Verification
A wrong divider or tick count lengthens or shortens every high and low interval. The output vector then departs from the arithmetic prediction within one local tick of the fault, which is at most P+1 clocks. A shadow register that loads at the wrong moment shows up in the period where the write happens, as a pulse width that is neither the old value nor the new one. Running periods back to back with a new duty set written in every period means any slip in the wrap point builds up, and it is exposed at the next boundary. A decode fault shows up as a changed value on the next read of a neighbouring register.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int DATA_W   = 32;
  localparam int DUTY_W   = 8;
  localparam int PS_W     = 8;
  localparam int TICK_W   = 8;
  localparam int NIB_W    = PS_W / 2;
  localparam int PSLO_LSB = 0;
  localparam int PSHI_LSB = 11;
  localparam int RUN_BIT  = 9;
  localparam logic [7:0] OFS_CTRL  = 8'h50;
  localparam logic [7:0] OFS_INTEN = 8'h54;

  function automatic logic [DATA_W-1:0] pack_ctrl(logic [PS_W-1:0] ps, logic run);
    logic [DATA_W-1:0] w;
    w = '0;
    w[PSLO_LSB +: NIB_W] = ps[NIB_W-1:0];
    w[PSHI_LSB +: NIB_W] = ps[PS_W-1:NIB_W];
    w[RUN_BIT] = run;
    return w;
  endfunction
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic [PS_W-1:0]       ps_reg,
  output logic                  run_reg,
  output logic [NCH*DUTY_W-1:0] duty_reg_flat
);
  localparam int IDX_W = ADDR_W - 2;

  logic [DUTY_W-1:0] duty_q [NCH];
  logic              irq_q;
  logic [IDX_W-1:0]  idx;
  logic              aligned, hit_duty, hit_ctrl, hit_inten;
  logic [DATA_W-1:0] rd_val;
  logic              unused_wbits;

  assign idx       = addr[ADDR_W-1:2];
  assign aligned   = (addr[1:0] == 2'b00);
  assign hit_duty  = aligned && (idx < IDX_W'(NCH));
  assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
  assign hit_inten = (addr == ADDR_W'(OFS_INTEN));
  assign unused_wbits = ^{wdata[DATA_W-1:PSHI_LSB+NIB_W], wdata[RUN_BIT+1],
                          wdata[RUN_BIT-1:NIB_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_reg  <= '0;
      run_reg <= 1'b0;
      irq_q   <= 1'b0;
    end else if (wr_en) begin
      if (hit_ctrl) begin
        ps_reg  <= {wdata[PSHI_LSB +: NIB_W], wdata[PSLO_LSB +: NIB_W]};
        run_reg <= wdata[RUN_BIT];
      end
      if (hit_inten) irq_q <= wdata[0];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_duty
    always_ff @(posedge clk) begin
      if (rst)
        duty_q[i] <= '0;
      else if (wr_en && hit_duty && (idx == IDX_W'(i)))
        duty_q[i] <= wdata[DUTY_W-1:0];
    end
    assign duty_reg_flat[i*DUTY_W +: DUTY_W] = duty_q[i];
  end

  always_comb begin
    rd_val = '0;
    if (hit_ctrl) begin
      rd_val = pack_ctrl(ps_reg, run_reg);
    end else if (hit_inten) begin
      rd_val[0] = irq_q;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (hit_duty && (idx == IDX_W'(i)))
          rd_val[DUTY_W-1:0] = duty_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run_reg,
  input  logic [PS_W-1:0]   ps_reg,
  output logic              run,
  output logic              tick,
  output logic              load,
  output logic [PS_W-1:0]   div_cnt,
  output logic [TICK_W-1:0] tick_cnt,
  output logic [PS_W-1:0]   ps_act
);
  localparam logic [TICK_W-1:0] TICK_MAX = '1;

  logic wrap;

  assign tick = run && (div_cnt == ps_act);
  assign wrap = tick && (tick_cnt == TICK_MAX);
  assign load = !run || wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      div_cnt  <= '0;
      tick_cnt <= '0;
      ps_act   <= '0;
    end else begin
      run <= run_reg;
      if (!run) begin
        div_cnt  <= '0;
        tick_cnt <= '0;
      end else if (tick) begin
        div_cnt  <= '0;
        tick_cnt <= tick_cnt + 1'b1;
      end else begin
        div_cnt  <= div_cnt + 1'b1;
      end
      if (load) ps_act <= ps_reg;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              load,
  input  logic [TICK_W-1:0] tick_cnt,
  input  logic [DUTY_W-1:0] duty_reg,
  output logic [DUTY_W-1:0] duty_act,
  output logic              pwm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      duty_act <= '0;
      pwm_q    <= 1'b0;
    end else begin
      if (load) duty_act <= duty_reg;
      pwm_q <= run && (tick_cnt <= duty_act);
    end
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NCH-1:0]    pwm_out
);
  logic [PS_W-1:0]       ps_reg;
  logic                  run_reg;
  logic [NCH*DUTY_W-1:0] duty_reg_flat;
  logic [NCH*DUTY_W-1:0] duty_act_flat;
  logic                  run, tick, load;
  logic [PS_W-1:0]       div_cnt, ps_act;
  logic [TICK_W-1:0]     tick_cnt;

  pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ps_reg(ps_reg), .run_reg(run_reg),
    .duty_reg_flat(duty_reg_flat)
  );

  pwm_timebase u_tb (
    .clk(clk), .rst(rst), .run_reg(run_reg), .ps_reg(ps_reg), .run(run),
    .tick(tick), .load(load), .div_cnt(div_cnt), .tick_cnt(tick_cnt),
    .ps_act(ps_act)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_channel u_ch (
      .clk(clk), .rst(rst), .run(run), .load(load), .tick_cnt(tick_cnt),
      .duty_reg(duty_reg_flat[i*DUTY_W +: DUTY_W]),
      .duty_act(duty_act_flat[i*DUTY_W +: DUTY_W]),
      .pwm_q(pwm_out[i])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [PS_W-1:0]       ps_reg,
  input logic                  run_reg,
  input logic [NCH*DUTY_W-1:0] duty_reg_flat,
  input logic                  run,
  input logic                  tick,
  input logic [PS_W-1:0]       div_cnt,
  input logic [TICK_W-1:0]     tick_cnt,
  input logic [PS_W-1:0]       ps_act,
  input logic [NCH*DUTY_W-1:0] duty_act_flat,
  input logic [NCH-1:0]        pwm_out
);
  logic mapped, at_wrap;
  assign mapped = (addr == ADDR_W'(OFS_CTRL)) || (addr == ADDR_W'(OFS_INTEN)) ||
                  ((addr[1:0] == 2'b00) && (int'(addr) < 4 * NCH));
  assign at_wrap = tick && (tick_cnt == '1);

  // R4: unmapped write leaves registers alone
  p_unmapped_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mapped) |=> ($stable(ps_reg) && $stable(run_reg) && $stable(duty_reg_flat)));

  p_div_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run |-> (div_cnt <= ps_act));

  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> $stable(tick_cnt));

  p_full_high_r6: assert property (@(posedge clk) disable iff (rst)
    (run && duty_act_flat[DUTY_W-1:0] == '1) |=> pwm_out[0]);

  p_short_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (run && tick_cnt != '0 && duty_act_flat[DUTY_W-1:0] == '0) |=> !pwm_out[0]);

  p_ps_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !at_wrap) |=> $stable(ps_act));

  p_duty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (run && !at_wrap) |=> $stable(duty_act_flat));

  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pwm_out == '0));
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .ps_reg(ps_reg),
  .run_reg(run_reg), .duty_reg_flat(duty_reg_flat), .run(run), .tick(tick),
  .div_cnt(div_cnt), .tick_cnt(tick_cnt), .ps_act(ps_act),
  .duty_act_flat(duty_act_flat), .pwm_out(pwm_out)
);

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
  import pwm_bank_pkg::*;
  localparam int NCH = 4;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  int cur_ps, nxt_ps;
  int cur_duty [NCH];
  int nxt_duty [NCH];
  logic [31:0] rv;

  always #4 clk = ~clk;

  pwm_bank #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // called at a falling edge; returns one falling edge after the write edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // one full period, checked every clock; stages the next values mid-period
  task automatic run_period(input string req);
    int len;
    logic [NCH-1:0] exp;
    len = 256 * (cur_ps + 1);
    for (int m = 0; m < len; m++) begin
      @(negedge clk);
      wr_en = 1'b0;
      for (int i = 0; i < NCH; i++)
        exp[i] = (((m / (cur_ps + 1)) % 256) <= cur_duty[i]);
      check(req, 32'(pwm_out), 32'(exp));
      if (m >= 10 && m < 10 + NCH) begin
        wr_en = 1'b1; addr = 8'(4 * (m - 10)); wdata = 32'(nxt_duty[m - 10]);
      end else if (m == 10 + NCH) begin
        wr_en = 1'b1; addr = OFS_CTRL; wdata = pack_ctrl(8'(nxt_ps), 1'b1);
      end
    end
    cur_ps = nxt_ps;
    for (int i = 0; i < NCH; i++) cur_duty[i] = nxt_duty[i];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R5 actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10 outputs", 32'(pwm_out), 32'h0);
    rd(8'h00, rv); check("R10 duty0", rv, 32'h0);
    rd(OFS_CTRL, rv); check("R10 ctrl", rv, 32'h0);
    rd(OFS_INTEN, rv); check("R10 inten", rv, 32'h0);

    // R1: duty field width and placement
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, rv); check("R1 duty1 all-ones", rv, 32'h0000_00FF);
    wr(8'h0C, 32'h1234_5677);
    rd(8'h0C, rv); check("R1 duty3", rv, 32'h0000_0077);
    rd(8'h00, rv); check("R1 duty0 untouched", rv, 32'h0);

    // R2: control fields
    wr(OFS_CTRL, 32'hFFFF_FFFF);
    rd(OFS_CTRL, rv); check("R2 ctrl all-ones", rv, 32'h0000_7A0F);
    wr(OFS_CTRL, 32'h0000_4803);
    rd(OFS_CTRL, rv); check("R2 ctrl nibbles", rv, 32'h0000_4803);
    wr(OFS_CTRL, 32'h0);
    repeat (4) @(negedge clk);
    check("R9 idle after stop", 32'(pwm_out), 32'h0);

    // R4: unmapped and misaligned writes
    wr(8'h10, 32'hAB);
    wr(8'h01, 32'h55);
    wr(8'h58, 32'hFFFF_FFFF);
    wr(8'h51, 32'hFFFF_FFFF);
    rd(8'h10, rv); check("R4 read unmapped 0x10", rv, 32'h0);
    rd(8'h58, rv); check("R4 read unmapped 0x58", rv, 32'h0);
    rd(8'h00, rv); check("R4 duty0 after stray writes", rv, 32'h0);
    rd(8'h04, rv); check("R4 duty1 after stray writes", rv, 32'hFF);
    rd(OFS_CTRL, rv); check("R4 ctrl after stray writes", rv, 32'h0);

    // duty sweep over all 256 values, new set staged every period (R6, R8)
    for (int i = 0; i < NCH; i++) begin
      cur_duty[i] = i;
      wr(8'(4 * i), 32'(i));
    end
    cur_ps = 0;
    wr(OFS_CTRL, pack_ctrl(8'd0, 1'b1));
    @(negedge clk);
    for (int p = 0; p < 64; p++) begin
      if (p < 63) begin
        nxt_ps = 0;
        for (int i = 0; i < NCH; i++) nxt_duty[i] = 4 * (p + 1) + i;
      end else begin
        nxt_ps = 2;
        nxt_duty[0] = 255; nxt_duty[1] = 0; nxt_duty[2] = 128; nxt_duty[3] = 7;
      end
      run_period(p == 0 ? "R7 start" : "R6 R8 duty sweep");
    end
    // prescaler variants, each taking effect at the boundary (R5, R8)
    nxt_ps = 1;  nxt_duty[0] = 0;   nxt_duty[1] = 255; nxt_duty[2] = 64;  nxt_duty[3] = 200;
    run_period("R5 R8 ps=2");
    nxt_ps = 16; nxt_duty[0] = 1;   nxt_duty[1] = 254; nxt_duty[2] = 127; nxt_duty[3] = 0;
    run_period("R5 R8 ps=1");
    nxt_ps = 33; nxt_duty[0] = 255; nxt_duty[1] = 3;   nxt_duty[2] = 99;  nxt_duty[3] = 180;
    run_period("R5 R8 ps=16");
    nxt_ps = 255; nxt_duty[0] = 17; nxt_duty[1] = 255; nxt_duty[2] = 0;   nxt_duty[3] = 240;
    run_period("R5 R8 ps=33");
    nxt_ps = 0;  nxt_duty[0] = 5;   nxt_duty[1] = 10;  nxt_duty[2] = 250; nxt_duty[3] = 0;
    run_period("R5 R8 ps=255");

    // R9: stop drives outputs low two edges after the write
    wr(OFS_CTRL, pack_ctrl(8'd0, 1'b0));
    @(negedge clk);
    @(negedge clk);
    check("R9 low after stop", 32'(pwm_out), 32'h0);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (k % 50 == 0) check("R9 stays low", 32'(pwm_out), 32'h0);
    end

    // R3: interrupt-enable flag stores, has no output effect
    wr(OFS_INTEN, 32'hFFFF_FFFF);
    rd(OFS_INTEN, rv); check("R3 inten readback", rv, 32'h1);
    check("R3 outputs unaffected while stopped", 32'(pwm_out), 32'h0);

    // R9 restart from tick 0 with the staged values; flag still set (R3)
    wr(OFS_CTRL, pack_ctrl(8'd0, 1'b1));
    @(negedge clk);
    run_period("R9 R3 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule